// File: doc/BRIEF.md
# Strided DMA Transfer Engine with Peripheral Handshake

This block moves a counted run of data units from a source address to a destination address for one DMA channel. It is loaded with a command word, two start addresses and a unit count. It then reads one unit from the source and writes it to the destination over a simple memory-master port, repeating this for every unit. After each access the address on that side moves forward by a step chosen in the command word. The step can be zero, which gives a fixed peripheral data register. Units are 8, 16 or 32 bits wide and are grouped into bursts of one or four.

A peripheral can pace the transfer through numbered request/acknowledge line pairs. One line can be chosen for the source side and one for the destination side. Before each burst the engine waits until every chosen request line is high. At the end of the burst it raises the matching acknowledge lines, and it keeps each one high until its request falls. When the count runs out, the engine clears the command's enable bit and, when asked to, sets a terminal flag. The current address, count and command values are always visible on output ports, so a register front end can read them back.

Top module: `stride_dma_engine`

## Requirements
- R1: Command bits 21:20 select the unit width: 0 gives 32 bits (memSize 2'b10), 1 gives 16 bits (memSize 2'b01), and 2 or 3 gives 8 bits (memSize 2'b00). Read data is right-aligned and masked to the unit width, and the same value is presented on memWdata for the following write.
- R2: Command bits 9:8 set the source step after each unit: 0 keeps the address, and 1, 2 and 3 add one, two and four unit sizes in bytes.
- R3: Command bits 13:12 set the destination step, with the same encoding as the source step.
- R4: Command bit 3 selects bursts of four units; when clear, each burst is one unit. Within a burst, each unit's read is followed by its write, and memReq stays high from the first read to the last write. A final burst that finds fewer units left than the burst length moves only those units.
- R5: Command bits 27:24 choose the source handshake line and bits 19:16 the destination line (1 to 15), and 0 means no handshake on that side. No burst starts while a chosen dmaReq line is low.
- R6: At the end of each burst, the acknowledge line of every chosen handshake line goes high. Each acknowledge stays high while its request stays high and drops in the cycle after the request is seen low.
- R7: The count falls by the units moved in each burst. When it reaches zero, cntOut reads 0, command bit 0 reads 0 and busy falls.
- R8: At completion, command bit 1 is set when command bit 2 is set, and it is left unchanged otherwise.
- R9: After completion, srcOut and dstOut hold the start addresses advanced by the unit count times the respective step.
- R10: A configuration write with command bit 0 clear, while the engine waits for a handshake between bursts, returns it to idle. This does not set bit 1, and no further memory access is made.
- R11: A configuration write that arrives while a burst is in progress (memReq high) is ignored.
- R12: After reset the engine is idle: busy, memReq and all dmaAck bits are 0, and cmdOut and cntOut read 0.
- R13: Starting with a count of zero completes without any memory access and applies R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Load all four configuration values (taken only while no burst is in progress) |
| cfgCmd | input | 32 | Command word |
| cfgSrc | input | AW | Source start address |
| cfgDst | input | AW | Destination start address |
| cfgCnt | input | CW | Unit count |
| cmdOut | output | 32 | Current command word including enable and terminal flag |
| srcOut | output | AW | Current source address |
| dstOut | output | AW | Current destination address |
| cntOut | output | CW | Units remaining |
| busy | output | 1 | Engine not idle |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | AW | Byte address of the access |
| memSize | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| memWdata | output | 32 | Write data, right-aligned |
| memRdata | input | 32 | Read data, valid in the cycle the read is accepted |
| memRdy | input | 1 | Access accepted at this clock edge |
| dmaReq | input | HS_LINES | Peripheral request lines |
| dmaAck | output | HS_LINES | Peripheral acknowledge lines |

## Verification
The hardest case to reach is a configuration write that lands in the few cycles when the engine sits between bursts, waiting on a request line. An abort there must return the engine to idle with no terminal flag, while the same write one cycle into a burst must be ignored. The bench reaches the first case by leaving the selected peripheral's request low, so the engine parks in its wait state, and then writing a disabled command. It reaches the second by watching memReq at the falling edge and pulsing cfgWr in that same cycle. The random transfers add memory back-pressure and paced handshakes on top, so bursts stretch and the short final burst shows up with every width and step.

// File: rtl/stride_dma_pkg.sv
package stride_dma_pkg;

  // Command word field positions (decoded by this engine and its neighbours)
  localparam int EN_BIT     = 0;
  localparam int TERM_BIT   = 1;
  localparam int IE_BIT     = 2;
  localparam int BURST_BIT  = 3;
  localparam int SSTEP_LSB  = 8;
  localparam int DSTEP_LSB  = 12;
  localparam int DHS_LSB    = 16;
  localparam int WIDTH_LSB  = 20;
  localparam int SHS_LSB    = 24;
  localparam int SEL_W      = 4;

  localparam int BURST_LONG = 4;
  localparam int UNIT_W     = $clog2(BURST_LONG + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_END
  } engState_t;

  typedef struct packed {
    logic loadCfg;
    logic latchRd;
    logic stepSrc;
    logic stepDst;
    logic endBurst;
    logic finish;
    logic setAck;
  } ctlStrobes_t;

endpackage

// File: rtl/stride_dma_dpath.sv
module stride_dma_dpath
  import stride_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [31:0]       cfgCmd,
  input  logic [AW-1:0]     cfgSrc,
  input  logic [AW-1:0]     cfgDst,
  input  logic [CW-1:0]     cfgCnt,
  input  logic [31:0]       memRdata,
  output logic [31:0]       cmdQ,
  output logic [AW-1:0]     srcQ,
  output logic [AW-1:0]     dstQ,
  output logic [CW-1:0]     cntQ,
  output logic [31:0]       dataQ,
  output logic [1:0]        sizeCode,
  output logic              cntZero,
  output logic              lastBurst,
  output logic [UNIT_W-1:0] takenUnits
);

  localparam int SHW = 3;

  logic [1:0]        widthSel;
  logic [1:0]        unitShift;
  logic [31:0]       sizeMask;
  logic [AW-1:0]     srcStep;
  logic [AW-1:0]     dstStep;
  logic [UNIT_W-1:0] burstLen;

  assign widthSel = cmdQ[WIDTH_LSB +: 2];

  always_comb begin
    unique case (widthSel)
      2'd0:    begin unitShift = 2'd2; sizeCode = 2'b10; sizeMask = 32'hFFFF_FFFF; end
      2'd1:    begin unitShift = 2'd1; sizeCode = 2'b01; sizeMask = 32'h0000_FFFF; end
      default: begin unitShift = 2'd0; sizeCode = 2'b00; sizeMask = 32'h0000_00FF; end
    endcase
  end

  function automatic logic [AW-1:0] stepOf(input logic [1:0] code, input logic [1:0] shiftBase);
    logic [SHW-1:0] amount;
    amount = SHW'(shiftBase) + SHW'(code) - SHW'(1);
    if (code == 2'd0) return '0;
    return AW'(1) << amount;
  endfunction

  assign srcStep = stepOf(cmdQ[SSTEP_LSB +: 2], unitShift);
  assign dstStep = stepOf(cmdQ[DSTEP_LSB +: 2], unitShift);

  assign burstLen   = cmdQ[BURST_BIT] ? UNIT_W'(BURST_LONG) : UNIT_W'(1);
  assign cntZero    = (cntQ == '0);
  assign lastBurst  = (cntQ <= CW'(burstLen));
  assign takenUnits = lastBurst ? cntQ[UNIT_W-1:0] : burstLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= '0;
      srcQ  <= '0;
      dstQ  <= '0;
      cntQ  <= '0;
      dataQ <= '0;
    end else begin
      if (stb.loadCfg) begin
        cmdQ <= cfgCmd;
        srcQ <= cfgSrc;
        dstQ <= cfgDst;
        cntQ <= cfgCnt;
      end else begin
        if (stb.stepSrc)  srcQ <= srcQ + srcStep;
        if (stb.stepDst)  dstQ <= dstQ + dstStep;
        if (stb.endBurst) cntQ <= cntQ - CW'(takenUnits);
        if (stb.finish) begin
          cmdQ[EN_BIT] <= 1'b0;
          if (cmdQ[IE_BIT]) cmdQ[TERM_BIT] <= 1'b1;
        end
      end
      if (stb.latchRd) dataQ <= memRdata & sizeMask;
    end
  end

endmodule

// File: rtl/stride_dma_hshake.sv
module stride_dma_hshake
  import stride_dma_pkg::*;
#(
  parameter int HS_LINES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [HS_LINES-1:0] dmaReq,
  input  logic [SEL_W-1:0]    srcLine,
  input  logic [SEL_W-1:0]    dstLine,
  input  logic                setAck,
  output logic [HS_LINES-1:0] dmaAck,
  output logic                hsReady
);

  logic srcOk;
  logic dstOk;

  assign srcOk   = (srcLine == '0) || dmaReq[srcLine];
  assign dstOk   = (dstLine == '0) || dmaReq[dstLine];
  assign hsReady = srcOk && dstOk;

  // Line 0 means "no handshake" and never acknowledges
  assign dmaAck[0] = 1'b0;

  for (genvar n = 1; n < HS_LINES; n++) begin : g_ack
    logic picked;
    logic ackQ;
    assign picked = (srcLine == SEL_W'(n)) || (dstLine == SEL_W'(n));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 ackQ <= 1'b0;
      else if (setAck && picked) ackQ <= 1'b1;
      else if (!dmaReq[n])       ackQ <= 1'b0;
    end
    assign dmaAck[n] = ackQ;
  end

endmodule

// File: rtl/stride_dma_ctrl.sv
module stride_dma_ctrl
  import stride_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgEnable,
  input  logic              cntZero,
  input  logic              lastBurst,
  input  logic [UNIT_W-1:0] takenUnits,
  input  logic              hsReady,
  input  logic              memRdy,
  output ctlStrobes_t       stb,
  output logic              memReq,
  output logic              memWe,
  output logic              busy
);

  engState_t         state;
  engState_t         nextState;
  logic [UNIT_W-1:0] unitsLeft;
  logic              accept;

  assign accept = cfgWr && ((state == ST_IDLE) || (state == ST_WAIT));
  assign busy   = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          stb.loadCfg = 1'b1;
          if (cfgEnable) nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (accept) begin
          stb.loadCfg = 1'b1;
          if (!cfgEnable) nextState = ST_IDLE;
        end else if (cntZero) begin
          stb.finish = 1'b1;
          nextState  = ST_IDLE;
        end else if (hsReady) begin
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memRdy) begin
          stb.latchRd = 1'b1;
          stb.stepSrc = 1'b1;
          nextState   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memRdy) begin
          stb.stepDst = 1'b1;
          nextState   = (unitsLeft == UNIT_W'(1)) ? ST_END : ST_READ;
        end
      end
      ST_END: begin
        stb.endBurst = 1'b1;
        stb.setAck   = 1'b1;
        if (lastBurst) begin
          stb.finish = 1'b1;
          nextState  = ST_IDLE;
        end else begin
          nextState = ST_WAIT;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      unitsLeft <= '0;
    end else begin
      state <= nextState;
      if ((state == ST_WAIT) && (nextState == ST_READ))
        unitsLeft <= takenUnits;
      else if (stb.stepDst)
        unitsLeft <= unitsLeft - UNIT_W'(1);
    end
  end

endmodule

// File: rtl/stride_dma_engine.sv
module stride_dma_engine
  import stride_dma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CW       = 24,
  parameter int HS_LINES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [31:0]         cfgCmd,
  input  logic [AW-1:0]       cfgSrc,
  input  logic [AW-1:0]       cfgDst,
  input  logic [CW-1:0]       cfgCnt,
  output logic [31:0]         cmdOut,
  output logic [AW-1:0]       srcOut,
  output logic [AW-1:0]       dstOut,
  output logic [CW-1:0]       cntOut,
  output logic                busy,
  output logic                memReq,
  output logic                memWe,
  output logic [AW-1:0]       memAddr,
  output logic [1:0]          memSize,
  output logic [31:0]         memWdata,
  input  logic [31:0]         memRdata,
  input  logic                memRdy,
  input  logic [HS_LINES-1:0] dmaReq,
  output logic [HS_LINES-1:0] dmaAck
);

  ctlStrobes_t       stb;
  logic [31:0]       dataQ;
  logic              cntZero;
  logic              lastBurst;
  logic [UNIT_W-1:0] takenUnits;
  logic              hsReady;

  stride_dma_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .cfgEnable  (cfgCmd[EN_BIT]),
    .cntZero    (cntZero),
    .lastBurst  (lastBurst),
    .takenUnits (takenUnits),
    .hsReady    (hsReady),
    .memRdy     (memRdy),
    .stb        (stb),
    .memReq     (memReq),
    .memWe      (memWe),
    .busy       (busy)
  );

  stride_dma_dpath #(.AW(AW), .CW(CW)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgCmd     (cfgCmd),
    .cfgSrc     (cfgSrc),
    .cfgDst     (cfgDst),
    .cfgCnt     (cfgCnt),
    .memRdata   (memRdata),
    .cmdQ       (cmdOut),
    .srcQ       (srcOut),
    .dstQ       (dstOut),
    .cntQ       (cntOut),
    .dataQ      (dataQ),
    .sizeCode   (memSize),
    .cntZero    (cntZero),
    .lastBurst  (lastBurst),
    .takenUnits (takenUnits)
  );

  stride_dma_hshake #(.HS_LINES(HS_LINES)) u_hshake (
    .clk     (clk),
    .rstN    (rstN),
    .dmaReq  (dmaReq),
    .srcLine (cmdOut[SHS_LSB +: SEL_W]),
    .dstLine (cmdOut[DHS_LSB +: SEL_W]),
    .setAck  (stb.setAck),
    .dmaAck  (dmaAck),
    .hsReady (hsReady)
  );

  assign memAddr  = memWe ? dstOut : srcOut;
  assign memWdata = dataQ;

endmodule

// File: rtl/stride_dma_chk.sv
module stride_dma_chk #(
  parameter int AW       = 32,
  parameter int CW       = 24,
  parameter int HS_LINES = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWr,
  input logic [31:0]         cmdOut,
  input logic [CW-1:0]       cntOut,
  input logic                busy,
  input logic                memReq,
  input logic [1:0]          memSize,
  input logic [HS_LINES-1:0] dmaReq,
  input logic [HS_LINES-1:0] dmaAck
);

  logic [3:0] srcSel;
  logic [3:0] dstSel;
  logic       selReqHigh;

  assign srcSel     = cmdOut[27:24];
  assign dstSel     = cmdOut[19:16];
  assign selReqHigh = ((srcSel == 4'd0) || dmaReq[srcSel]) &&
                      ((dstSel == 4'd0) || dmaReq[dstSel]);

  // R1
  size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memSize != 2'b11));

  // R5
  burst_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(selReqHigh));

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(dmaAck & dmaReq)) |=> ((dmaAck & $past(dmaAck & dmaReq)) == $past(dmaAck & dmaReq)));

  // R7
  done_clears_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !cmdOut[0]);

  // R8
  term_needs_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdOut[1]) |-> (cmdOut[2] || $past(cfgWr)));

  // R11
  cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && cfgWr) |=> ($stable(cntOut) && $stable(cmdOut)));

endmodule

bind stride_dma_engine stride_dma_chk #(.AW(AW), .CW(CW), .HS_LINES(HS_LINES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWr   (cfgWr),
  .cmdOut  (cmdOut),
  .cntOut  (cntOut),
  .busy    (busy),
  .memReq  (memReq),
  .memSize (memSize),
  .dmaReq  (dmaReq),
  .dmaAck  (dmaAck)
);

// File: tb/tb_stride_dma_engine.sv
`timescale 1ns/1ps
module tb_stride_dma_engine;

  localparam int AW = 32;
  localparam int CW = 24;
  localparam int HL = 16;
  localparam int RECMAX = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWr = 1'b0;
  logic [31:0]   cfgCmd = '0;
  logic [AW-1:0] cfgSrc = '0;
  logic [AW-1:0] cfgDst = '0;
  logic [CW-1:0] cfgCnt = '0;
  logic [31:0]   cmdOut;
  logic [AW-1:0] srcOut;
  logic [AW-1:0] dstOut;
  logic [CW-1:0] cntOut;
  logic          busy;
  logic          memReq;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [1:0]    memSize;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata;
  logic          memRdy = 1'b0;
  logic [HL-1:0] dmaReq = '0;
  logic [HL-1:0] dmaAck;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // peripheral and monitor state
  logic [HL-1:0] perEn = '0;
  logic [HL-1:0] prevAck = '0;
  logic          prevReq = 1'b0;
  int            rdyPct = 75;
  int            recN = 0;
  int            burstRises = 0;
  int            ackRises [HL];
  logic          recWe   [RECMAX];
  logic [AW-1:0] recAddr [RECMAX];
  logic [1:0]    recSize [RECMAX];
  logic [31:0]   recData [RECMAX];

  always #4 clk = ~clk;

  stride_dma_engine #(.AW(AW), .CW(CW), .HS_LINES(HL)) dut (.*);

  function automatic logic [31:0] hashOf(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  assign memRdata = hashOf(memAddr);

  always @(negedge clk) begin
    dmaReq  = perEn & ~dmaAck;
    memRdy  = ($urandom % 100) < rdyPct;
    #1;
    if (memReq && memRdy && recN < RECMAX) begin
      recWe[recN]   = memWe;
      recAddr[recN] = memAddr;
      recSize[recN] = memSize;
      recData[recN] = memWdata;
      recN++;
    end
    if (memReq && !prevReq) burstRises++;
    prevReq = memReq;
    for (int n = 0; n < HL; n++)
      if (dmaAck[n] && !prevAck[n]) ackRises[n]++;
    prevAck = dmaAck;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input bit ie, input bit b4, input logic [1:0] w,
                                        input logic [1:0] ss, input logic [1:0] ds,
                                        input logic [3:0] shs, input logic [3:0] dhs);
    logic [31:0] c;
    c = '0;
    c[0] = 1'b1; c[2] = ie; c[3] = b4;
    c[9:8] = ss; c[13:12] = ds; c[19:16] = dhs; c[21:20] = w; c[27:24] = shs;
    return c;
  endfunction

  function automatic int unitBytes(input logic [1:0] w);
    return (w == 2'd0) ? 4 : (w == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic [AW-1:0] stepBytes(input logic [1:0] code, input logic [1:0] w);
    int ub;
    ub = unitBytes(w);
    return (code == 2'd0) ? '0 : AW'(ub << (code - 1));
  endfunction

  task automatic clearRec();
    recN = 0;
    burstRises = 0;
    for (int n = 0; n < HL; n++) ackRises[n] = 0;
  endtask

  task automatic writeCfg(input logic [31:0] c, input logic [AW-1:0] s, input logic [AW-1:0] d,
                          input logic [CW-1:0] n);
    @(negedge clk);
    cfgWr = 1'b1; cfgCmd = c; cfgSrc = s; cfgDst = d; cfgCnt = n;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkXfer(input logic [31:0] c, input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input int n, input string what);
    logic [1:0]    w;
    logic [AW-1:0] sStep, dStep, ra, wa;
    logic [1:0]    sz;
    logic [31:0]   mask;
    int            bl, bursts;
    w     = c[21:20];
    sStep = stepBytes(c[9:8], w);
    dStep = stepBytes(c[13:12], w);
    sz    = (w == 2'd0) ? 2'b10 : (w == 2'd1) ? 2'b01 : 2'b00;
    mask  = (w == 2'd0) ? 32'hFFFF_FFFF : (w == 2'd1) ? 32'h0000_FFFF : 32'h0000_00FF;
    bl    = c[3] ? 4 : 1;
    bursts = (n + bl - 1) / bl;
    chk(recN == 2 * n, {"R4 access count ", what}, recN, 2 * n);
    for (int i = 0; i < n && (2 * i + 1) < RECMAX; i++) begin
      ra = s + AW'(i) * sStep;
      wa = d + AW'(i) * dStep;
      chk(recWe[2*i] == 1'b0 && recWe[2*i+1] == 1'b1, {"R4 read-write order ", what},
          {recWe[2*i], recWe[2*i+1]}, 2'b01);
      chk(recAddr[2*i] == ra, {"R2 source address ", what}, recAddr[2*i], ra);
      chk(recAddr[2*i+1] == wa, {"R3 destination address ", what}, recAddr[2*i+1], wa);
      chk(recSize[2*i] == sz && recSize[2*i+1] == sz, {"R1 access size ", what},
          recSize[2*i+1], sz);
      chk(recData[2*i+1] == (hashOf(ra) & mask), {"R1 write data ", what},
          recData[2*i+1], hashOf(ra) & mask);
    end
    chk(burstRises == bursts, {"R4 burst count ", what}, burstRises, bursts);
    chk(srcOut == s + AW'(n) * sStep, {"R9 final source ", what}, srcOut, s + AW'(n) * sStep);
    chk(dstOut == d + AW'(n) * dStep, {"R9 final destination ", what}, dstOut, d + AW'(n) * dStep);
    chk(cntOut == '0, {"R7 count zero ", what}, cntOut, 0);
    chk(cmdOut[0] == 1'b0 && busy == 1'b0, {"R7 enable cleared ", what}, {cmdOut[0], busy}, 0);
    chk(cmdOut[1] == c[2], {"R8 terminal flag ", what}, cmdOut[1], c[2]);
    if (c[27:24] != 4'd0)
      chk(ackRises[c[27:24]] == bursts, {"R6 source ack count ", what}, ackRises[c[27:24]], bursts);
    if (c[19:16] != 4'd0 && c[19:16] != c[27:24])
      chk(ackRises[c[19:16]] == bursts, {"R6 dest ack count ", what}, ackRises[c[19:16]], bursts);
  endtask

  task automatic runXfer(input logic [31:0] c, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int n, input string what);
    clearRec();
    writeCfg(c, s, d, CW'(n));
    waitIdle();
    checkXfer(c, s, d, n, what);
  endtask

  initial begin
    logic [31:0] c;
    for (int n = 0; n < HL; n++) ackRises[n] = 0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(busy == 1'b0 && memReq == 1'b0, "R12 idle after reset", {busy, memReq}, 0);
    chk(dmaAck == '0, "R12 acks low after reset", dmaAck, 0);
    chk(cmdOut == '0 && cntOut == '0, "R12 registers cleared", cmdOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 short last burst, 32-bit, unit steps, interrupt enabled
    runXfer(mkCmd(1, 1, 2'd0, 2'd1, 2'd1, 4'd0, 4'd0), 32'h0000_1000, 32'h0000_8000, 10, "word b4");
    // R2 fixed source, R3 quad step, 8-bit, single bursts, no terminal flag
    runXfer(mkCmd(0, 0, 2'd2, 2'd0, 2'd3, 4'd0, 4'd0), 32'h0000_2003, 32'h0000_9001, 5, "byte fixed");
    // R1 16-bit, double steps
    runXfer(mkCmd(1, 1, 2'd1, 2'd2, 2'd2, 4'd0, 4'd0), 32'h0000_3002, 32'h0000_A000, 7, "half x2");

    // R13 zero count
    clearRec();
    writeCfg(mkCmd(1, 1, 2'd0, 2'd1, 2'd1, 4'd0, 4'd0), 32'h100, 32'h200, '0);
    waitIdle();
    chk(recN == 0, "R13 no access on zero count", recN, 0);
    chk(cmdOut[1] == 1'b1 && cmdOut[0] == 1'b0, "R13 completes with terminal flag", cmdOut[1:0], 2'b10);

    // R5 stall until request, R6 acks per burst
    clearRec();
    perEn = '0;
    c = mkCmd(1, 1, 2'd0, 2'd1, 2'd0, 4'd3, 4'd9);
    writeCfg(c, 32'h0000_4000, 32'h0000_B000, 24'd6);
    repeat (20) @(negedge clk);
    chk(burstRises == 0 && busy == 1'b1, "R5 stall while request low", burstRises, 0);
    perEn[3] = 1'b1;
    repeat (10) @(negedge clk);
    chk(burstRises == 0, "R5 stall while dest request low", burstRises, 0);
    perEn[9] = 1'b1;
    waitIdle();
    checkXfer(c, 32'h0000_4000, 32'h0000_B000, 6, "paced");
    repeat (4) @(negedge clk);
    chk(dmaAck == '0, "R6 acks drop with requests", dmaAck, 0);
    perEn = '0;

    // R10 abort while waiting on handshake
    clearRec();
    writeCfg(mkCmd(1, 0, 2'd0, 2'd1, 2'd1, 4'd5, 4'd0), 32'h500, 32'h600, 24'd3);
    repeat (10) @(negedge clk);
    c = 32'h0000_0004;
    c[27:24] = 4'd5;
    writeCfg(c, 32'h500, 32'h600, 24'd3);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R10 abort returns to idle", busy, 0);
    chk(cmdOut[1] == 1'b0, "R10 abort sets no terminal flag", cmdOut[1], 0);
    perEn[5] = 1'b1;
    repeat (20) @(negedge clk);
    chk(recN == 0 && dmaAck == '0, "R10 no access after abort", recN, 0);
    perEn = '0;

    // R11 configuration write during a burst is ignored
    clearRec();
    c = mkCmd(1, 1, 2'd0, 2'd1, 2'd1, 4'd0, 4'd0);
    writeCfg(c, 32'h0000_7000, 32'h0000_C000, 24'd8);
    while (!memReq) @(negedge clk);
    cfgWr = 1'b1; cfgCmd = mkCmd(0, 0, 2'd2, 2'd0, 2'd0, 4'd0, 4'd0);
    cfgSrc = 32'hDEAD_0000; cfgDst = 32'hBEEF_0000; cfgCnt = 24'd30;
    @(negedge clk);
    cfgWr = 1'b0;
    waitIdle();
    checkXfer(c, 32'h0000_7000, 32'h0000_C000, 8, "write mid-burst");

    // random transfers
    for (int t = 0; t < 30; t++) begin
      logic [3:0] shs, dhs;
      int n;
      shs = 4'd0; dhs = 4'd0;
      if ($urandom % 3 == 0) begin
        shs = 4'($urandom % 15 + 1);
        dhs = 4'($urandom % 16);
      end
      perEn = '1;
      rdyPct = 40 + int'($urandom % 61);
      n = 1 + int'($urandom % 20);
      c = mkCmd(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), shs, dhs);
      runXfer(c, AW'($urandom % 32'h10000), AW'(32'h0010_0000 + $urandom % 32'h10000), n, "random");
      perEn = '0;
      repeat (3) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule